// File: doc/BRIEF.md
# Clock Lane High-Speed Controller

This block sequences the clock lane of a serial link between its low-power stop state and a continuously running high-speed clock, and interlocks that clock with the data lanes. When the host raises a request, the lane leaves the stop state, drives a bridge state, then a high-speed zero, and then starts toggling. Only after a programmed number of toggling cycles does the block grant the data lanes permission to enter high speed.

The host lowers the request to ask for a stop. That stop is deferred for as long as the data lanes report that they are still busy. Once they report idle, the clock keeps running for a programmed post interval. The lane then holds a high-speed zero trail, drives the stop state for a programmed exit interval, and finally drops its acknowledge.

Every phase length is a cycle count on a configuration input. A count of zero is treated as one cycle. Each count is captured when its phase begins. The analog drivers are not part of this block. Its outputs are the requested line state, the high-speed enable and the clock level.

Top module: `clk_lane_hs_ctrl`

## Requirements
- R1: During and after reset with the request low, the lane is in stop: `lp_line` = 2'b11, `hs_en` = 0, `hs_clk` = 0, `data_go` = 0, `ack` = 0.
- R2: A high request seen in stop moves the lane, one cycle later, to `lp_line` = 2'b00 with `hs_en` = 0 for max(`len_prepare`,1) cycles.
- R3: After prepare, `hs_en` = 1 and `hs_clk` = 0 with `lp_line` = 2'b00 for max(`len_zero`,1) cycles.
- R4: After zero, `hs_clk` inverts on every cycle for as long as the clock runs, and it is 1 in the first running cycle.
- R5: `data_go` stays low during the first max(`len_pre`,1) running cycles and goes high in the cycle after them.
- R6: `ack` rises in the same cycle as `data_go` and stays high until the lane has returned to stop, when it falls together with `lp_line` becoming 2'b11 after exit.
- R7: While `data_idle` is 0, a low request is held. `data_go` stays 1 and the clock keeps toggling.
- R8: In the cycle after the request is low and `data_idle` is 1 while `data_go` is high, `data_go` falls. The clock then toggles for max(`len_post`,1) cycles, followed by max(`len_trail`,1) cycles of `hs_en` = 1 with `hs_clk` = 0.
- R9: After trail, the lane drives `lp_line` = 2'b11 with `hs_en` = 0 for max(`len_exit`,1) cycles and then reaches stop. A request raised during exit has no effect until stop is reached. It then starts a new prepare phase one cycle later.
- R10: Any phase count of zero gives that phase exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; one cycle is one clock-lane UI |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | High asks for the high-speed clock, low asks for stop |
| data_idle | input | 1 | High when all data lanes are back in low power |
| len_prepare | input | CW | Bridge-state length in cycles |
| len_zero | input | CW | High-speed zero length before toggling |
| len_pre | input | CW | Running cycles before data lanes are permitted |
| len_post | input | CW | Running cycles after data lanes go idle |
| len_trail | input | CW | High-speed zero length after the last clock cycle |
| len_exit | input | CW | Stop-state length before acknowledge drops |
| lp_line | output | 2 | Low-power line state (P,N) |
| hs_en | output | 1 | High-speed driver enable |
| hs_clk | output | 1 | High-speed clock level |
| data_go | output | 1 | Registered permission for data lanes to use high speed |
| ack | output | 1 | Handshake acknowledge |

## Verification
On every cycle, the assertions check the local interlocks. Permission is granted only with the high-speed driver on. Acknowledge accompanies the rise of permission. A busy data lane holds permission. The clock inverts while permission is held. Stop is quiet, and a request in stop leads to the bridge state. The exact phase lengths, the handling of zero counts, the start of the clock at 1, and a request that arrives during exit are shown only by the bench's scenarios, which compare against a cycle-by-cycle reference model.

// File: rtl/clk_lane_hs_ctrl.sv
module clk_lane_hs_ctrl #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          data_idle,
  input  logic [CW-1:0] len_prepare,
  input  logic [CW-1:0] len_zero,
  input  logic [CW-1:0] len_pre,
  input  logic [CW-1:0] len_post,
  input  logic [CW-1:0] len_trail,
  input  logic [CW-1:0] len_exit,
  output logic [1:0]    lp_line,
  output logic          hs_en,
  output logic          hs_clk,
  output logic          data_go,
  output logic          ack
);
  localparam logic [CW-1:0] ONE = CW'(1);

  typedef enum logic [2:0] {
    P_STOP, P_BRIDGE, P_ZERO, P_LEAD, P_RUN, P_TAIL, P_TRAIL, P_EXIT
  } phase_t;

  phase_t        ph, ph_d;
  logic [CW-1:0] cnt, cnt_d;
  logic          clk_q, go_q, ack_q;
  logic          toggling_d;

  function automatic logic [CW-1:0] ld(input logic [CW-1:0] v);
    return (v == '0) ? '0 : v - ONE;
  endfunction

  always_comb begin
    ph_d  = ph;
    cnt_d = cnt;
    unique case (ph)
      P_STOP: if (req) begin
        ph_d  = P_BRIDGE;
        cnt_d = ld(len_prepare);
      end
      P_RUN: if (!req && data_idle) begin
        ph_d  = P_TAIL;
        cnt_d = ld(len_post);
      end
      default: begin
        if (cnt != '0) begin
          cnt_d = cnt - ONE;
        end else begin
          unique case (ph)
            P_BRIDGE: begin ph_d = P_ZERO;  cnt_d = ld(len_zero);  end
            P_ZERO:   begin ph_d = P_LEAD;  cnt_d = ld(len_pre);   end
            P_LEAD:   ph_d = P_RUN;
            P_TAIL:   begin ph_d = P_TRAIL; cnt_d = ld(len_trail); end
            P_TRAIL:  begin ph_d = P_EXIT;  cnt_d = ld(len_exit);  end
            P_EXIT:   ph_d = P_STOP;
            default:  ph_d = P_STOP;
          endcase
        end
      end
    endcase
  end

  assign toggling_d = (ph_d == P_LEAD) || (ph_d == P_RUN) || (ph_d == P_TAIL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph    <= P_STOP;
      cnt   <= '0;
      clk_q <= 1'b0;
      go_q  <= 1'b0;
      ack_q <= 1'b0;
    end else begin
      ph    <= ph_d;
      cnt   <= cnt_d;
      clk_q <= toggling_d ? ~clk_q : 1'b0;
      go_q  <= (ph_d == P_RUN);
      ack_q <= (ph_d == P_RUN) || (ph_d == P_TAIL) || (ph_d == P_TRAIL) || (ph_d == P_EXIT);
    end
  end

  assign lp_line = (ph == P_STOP || ph == P_EXIT) ? 2'b11 : 2'b00;
  assign hs_en   = !(ph == P_STOP || ph == P_BRIDGE || ph == P_EXIT);
  assign hs_clk  = clk_q;
  assign data_go = go_q;
  assign ack     = ack_q;
endmodule

module clk_lane_hs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req,
  input logic       data_idle,
  input logic [1:0] lp_line,
  input logic       hs_en,
  input logic       hs_clk,
  input logic       data_go,
  input logic       ack
);
  a_r5_go_needs_hs: assert property (@(posedge clk) disable iff (!rst_n)
    data_go |-> (hs_en && lp_line == 2'b00));

  a_r6_ack_with_go: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_go) |-> ack);

  a_r7_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (data_go && !data_idle) |=> data_go);

  a_r4_clock_inverts: assert property (@(posedge clk) disable iff (!rst_n)
    (data_go && $past(data_go)) |-> (hs_clk != $past(hs_clk)));

  a_r2_stop_to_bridge: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_line == 2'b11 && !ack && req) |=> (lp_line == 2'b00 && !hs_en));

  a_r9_lp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_line == 2'b11) |-> (!hs_en && !hs_clk && !data_go));
endmodule

bind clk_lane_hs_ctrl clk_lane_hs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .data_idle(data_idle),
  .lp_line(lp_line), .hs_en(hs_en), .hs_clk(hs_clk),
  .data_go(data_go), .ack(ack)
);

// File: tb/tb_clk_lane_hs_ctrl.sv
module tb_clk_lane_hs_ctrl;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic data_idle = 1'b1;
  logic [CW-1:0] lp_len = 8'd3, z_len = 8'd4, pre_len = 8'd8;
  logic [CW-1:0] post_len = 8'd6, tr_len = 8'd5, ex_len = 8'd7;
  logic [1:0] lp_line;
  logic hs_en, hs_clk, data_go, ack;

  always #4 clk = ~clk;

  clk_lane_hs_ctrl #(.CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .data_idle(data_idle),
    .len_prepare(lp_len), .len_zero(z_len), .len_pre(pre_len),
    .len_post(post_len), .len_trail(tr_len), .len_exit(ex_len),
    .lp_line(lp_line), .hs_en(hs_en), .hs_clk(hs_clk),
    .data_go(data_go), .ack(ack)
  );

  // reference: 0 stop,1 bridge,2 zero,3 lead,4 run,5 tail,6 trail,7 exit
  int m_ph = 0, m_el = 0, m_tgt = 0;
  bit m_clk = 0;
  bit zero_case = 0;
  int vectors = 0, fails = 0, cycles = 0;

  function automatic int lenof(input logic [CW-1:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  function automatic string tag_of(input int p);
    if (zero_case && p != 0 && p != 4) return "R10";
    case (p)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R5";
      4: return "R7";
      5, 6: return "R8";
      default: return "R9";
    endcase
  endfunction

  always @(posedge clk) begin
    int np;
    if (!rst_n) begin
      m_ph = 0; m_el = 0; m_tgt = 0; m_clk = 0;
    end else begin
      np = m_ph;
      if (m_ph == 0) begin
        if (req) np = 1;
      end else if (m_ph == 4) begin
        if (!req && data_idle) np = 5;
      end else if (m_el >= m_tgt) begin
        np = (m_ph == 7) ? 0 : m_ph + 1;
      end else begin
        m_el++;
      end
      if (np != m_ph) begin
        m_el = 1;
        case (np)
          1: m_tgt = lenof(lp_len);
          2: m_tgt = lenof(z_len);
          3: m_tgt = lenof(pre_len);
          5: m_tgt = lenof(post_len);
          6: m_tgt = lenof(tr_len);
          7: m_tgt = lenof(ex_len);
          default: m_tgt = 0;
        endcase
      end
      m_clk = (np >= 3 && np <= 5) ? ~m_clk : 1'b0;
      m_ph = np;
    end
  end

  always @(negedge clk) begin
    logic [1:0] e_lp;
    bit e_hs, e_go, e_ack;
    e_lp  = (m_ph == 0 || m_ph == 7) ? 2'b11 : 2'b00;
    e_hs  = !(m_ph == 0 || m_ph == 1 || m_ph == 7);
    e_go  = (m_ph == 4);
    e_ack = (m_ph >= 4);
    vectors++;
    if (lp_line !== e_lp || hs_en !== e_hs || hs_clk !== m_clk || data_go !== e_go) begin
      fails++;
      $display("FAIL %s t=%0t lp=%b hs=%b clk=%b go=%b expected lp=%b hs=%b clk=%b go=%b",
               tag_of(m_ph), $time, lp_line, hs_en, hs_clk, data_go, e_lp, e_hs, m_clk, e_go);
    end
    if (ack !== e_ack) begin
      fails++;
      $display("FAIL R6 t=%0t ack=%b expected %b", $time, ack, e_ack);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_stop();
    int guard = 0;
    do begin step(1); guard++; end while ((m_ph != 0) && guard < 500);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    step(3);                         // R1: reset state compared each cycle
    rst_n = 1'b1;
    step(3);                         // R1: idle stop after reset
    // R2 R3 R4 R5 R8 R9: plain burst, lanes idle
    req = 1'b1; step(30);
    req = 1'b0; wait_stop(); step(2);
    // R7: stop request held while lanes busy
    req = 1'b1; data_idle = 1'b0; step(25);
    req = 1'b0; step(12);
    data_idle = 1'b1; wait_stop(); step(2);
    // R10: all phase counts zero
    zero_case = 1;
    lp_len = 0; z_len = 0; pre_len = 0; post_len = 0; tr_len = 0; ex_len = 0;
    req = 1'b1; step(6);
    req = 1'b0; wait_stop(); step(2);
    zero_case = 0;
    // R9: request raised during exit, restart after stop
    lp_len = 2; z_len = 3; pre_len = 4; post_len = 3; tr_len = 2; ex_len = 9;
    req = 1'b1; step(15);
    req = 1'b0;
    while (m_ph != 7) step(1);
    step(2); req = 1'b1; step(30);
    // R5 R6: request dropped before permission, single run cycle
    req = 1'b0; wait_stop(); step(1);
    req = 1'b1; step(3); req = 1'b0;
    wait_stop(); step(3);
    // R4: long pre count then long run
    pre_len = 8'd40; req = 1'b1; step(80);
    req = 1'b0; wait_stop(); step(3);
    finish_run();
  end
endmodule